// File: doc/BRIEF.md
# ECC Syndrome to DIMM Locator

This block turns a corrected-error report into a physical location on the memory modules. It takes an error syndrome code, the byte offset of the failing address within its 64-byte cache line, and the identity of the bank that decoded the address. From these it finds the DIMM, and for a single-bit error the connector pin, that carries the faulty bit. A cache line crosses the data bus as four quadwords of 144 bits. The block converts the syndrome into a bit position inside that 576-bit transfer. It then reads a packed per-bit DIMM-select table and a per-bit pin table, both held in on-chip RAM.

Two complete table sets are stored. A configuration pin picks one of them for each request: set 0 for a symmetric population, set 1 otherwise. For a multi-bit error the block reports the whole group of four DIMMs behind the bank. An out-of-range code, an address that no bank decodes, or a bit position that falls outside the line all produce an "unknown" result.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. Only one request is in flight at a time. `req_ready` stays low from acceptance until the consumer takes the result. A result that is not taken holds its value for as long as `res_ready` stays low. The tables are loaded through a plain byte-wide write port.

Top module: `ecc_dimm_locator`

## Requirements
- R1: After reset, `req_ready` is 1 and `res_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `res_valid` rises exactly two edges after acceptance. `req_ready` stays 0 from the acceptance edge until the edge where the result is taken (`res_valid` and `res_ready` both 1), and returns to 1 after that edge.
- R3: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_kind`, `res_dimm` and `res_pin` hold their values.
- R4: The result is unknown (`res_kind` = 0, `res_dimm` = 0, `res_pin` = 0) in any of these cases: `req_bank_hit` is 0, the signed syndrome is below -1, or the signed syndrome is above 144.
- R5: A syndrome of -1 is a multi-bit error. It gives `res_kind` = 2, `res_pin` = 0, and `res_dimm` = (bank mod 2) x 4, which is the first of the four DIMMs in the group.
- R6: A syndrome s from 0 to 144 is remapped to a code r as follows: for s < 128, r = s + 16; for 128 <= s < 144, r = s - 137; for s = 144, r = 1.
- R7: The quadword is q = offset[5:4]. The line position is p = (3 - q) x 144 + r. If p < 0 or p > 575, the result is unknown.
- R8: For a single-bit result, `res_kind` = 1. Let v = 575 - p. The block reads DIMM-map byte v/4 and takes bit (3 - v mod 4) x 2 of that byte as the DIMM select. Then `res_dimm` = (bank mod 2) x 4 + select.
- R9: For a single-bit result, `res_pin` equals pin-map byte p.
- R10: `cfg_symmetric` is sampled at acceptance. A value of 1 selects table set 0 and a value of 0 selects set 1. A change to the pin after acceptance has no effect on that result.
- R11: A table write with `tbl_we` = 1 stores `tbl_data` at `tbl_addr` in the table chosen by `tbl_kind` (0 = DIMM map, 144 bytes; 1 = pin map, 576 bytes) of set `tbl_set`. Addresses at or beyond a table's size are ignored and do not alias onto lower entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_symmetric | input | 1 | 1 = use table set 0, 0 = use set 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_syndrome | input | 10 | Signed syndrome code (-1 = multi-bit) |
| req_offset | input | 6 | Byte offset of the address within its 64-byte line |
| req_bank_hit | input | 1 | 1 when some bank decodes the address |
| req_bank | input | 2 | Index of the decoding bank |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 unknown, 1 single-bit, 2 multi-bit |
| res_dimm | output | 3 | Faulty DIMM (single) or first DIMM of group (multi) |
| res_pin | output | 8 | Connector pin for a single-bit error |
| tbl_we | input | 1 | Table write enable |
| tbl_set | input | 1 | Table set to write |
| tbl_kind | input | 1 | 0 = DIMM map, 1 = pin map |
| tbl_addr | input | 10 | Byte address within the table |
| tbl_data | input | 8 | Byte to write |

## Verification
The bench builds the block with its default parameters: four quadwords of 144 bits, two groups of four DIMMs, a 10-bit signed syndrome and 10-bit table addresses. With these values every line position from 0 to 575 can be reached. So can the negative positions that codes 128 to 136 produce in quadword 3, and a DIMM-map write address of 261, which would alias onto byte 5 if the address were truncated. Both table sets are filled with random bytes and read through both values of the set-select pin. Results are randomly held back under stalls.

// File: rtl/ecc_loc_pkg.sv
`timescale 1ns/1ps
package ecc_loc_pkg;
  typedef enum logic [1:0] {
    LOC_UNKNOWN = 2'd0,
    LOC_SINGLE  = 2'd1,
    LOC_MULTI   = 2'd2
  } loc_kind_e;
endpackage

// File: rtl/ecc_loc_remap.sv
`timescale 1ns/1ps
// Syndrome to bus-bit translation: range checks, code remap, line position
// and the packed DIMM-map coordinates of the reversed position.
module ecc_loc_remap #(
  parameter int SYN_W   = 10,
  parameter int QW_BITS = 144,
  parameter int QW_NUM  = 4,
  parameter int QW_W    = 2,
  parameter int LP_W    = 10,
  parameter int DB_W    = 8
) (
  input  logic signed [SYN_W-1:0] syn_i,
  input  logic [QW_W-1:0]         qw_i,
  output logic                    in_range_o,
  output logic                    multi_o,
  output logic                    pos_ok_o,
  output logic [LP_W-1:0]         lp_o,
  output logic [DB_W-1:0]         dbyte_o,
  output logic [2:0]              shift_o
);
  localparam int LINE_BITS = QW_BITS * QW_NUM;
  localparam int LOW_SPAN  = QW_BITS - 16;

  int s, r, pos, rev;

  always_comb begin
    s          = int'(syn_i);
    in_range_o = (s >= -1) && (s <= QW_BITS);
    multi_o    = (s == -1);
    if (s < LOW_SPAN)         r = s + 16;
    else if (s < QW_BITS)     r = s - (QW_BITS - 7);
    else if (s < QW_BITS + 3) r = s - (QW_BITS - 1);
    else                      r = s - (QW_BITS + 3);
    pos      = (QW_NUM - 1 - int'(qw_i)) * QW_BITS + r;
    pos_ok_o = (pos >= 0) && (pos < LINE_BITS);
    rev      = pos_ok_o ? (LINE_BITS - 1 - pos) : 0;
    lp_o     = pos_ok_o ? LP_W'(pos) : '0;
    dbyte_o  = DB_W'(rev / 4);
    shift_o  = 3'((3 - (rev % 4)) * 2);
  end
endmodule

// File: rtl/ecc_loc_map_ram.sv
`timescale 1ns/1ps
// Byte table with a guarded write port and a registered read port.
module ecc_loc_map_ram #(
  parameter int DEPTH = 144,
  parameter int AW    = 10,
  parameter int RW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr[RW-1:0]] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_dimm_locator.sv
`timescale 1ns/1ps
module ecc_dimm_locator
  import ecc_loc_pkg::*;
#(
  parameter int QW_BITS         = 144,
  parameter int QW_NUM          = 4,
  parameter int QW_BYTES        = 16,
  parameter int GROUPS          = 2,
  parameter int DIMMS_PER_GROUP = 4,
  parameter int SYN_W           = 10,
  parameter int BANK_W          = 2,
  parameter int TA_W            = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_symmetric,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic signed [SYN_W-1:0]  req_syndrome,
  input  logic [$clog2(QW_NUM*QW_BYTES)-1:0] req_offset,
  input  logic                     req_bank_hit,
  input  logic [BANK_W-1:0]        req_bank,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [1:0]               res_kind,
  output logic [$clog2(GROUPS*DIMMS_PER_GROUP)-1:0] res_dimm,
  output logic [7:0]               res_pin,
  input  logic                     tbl_we,
  input  logic                     tbl_set,
  input  logic                     tbl_kind,
  input  logic [TA_W-1:0]          tbl_addr,
  input  logic [7:0]               tbl_data
);
  localparam int LINE_BITS  = QW_BITS * QW_NUM;
  localparam int DMAP_BYTES = LINE_BITS / 4;
  localparam int LP_W       = $clog2(LINE_BITS);
  localparam int DB_W       = $clog2(DMAP_BYTES);
  localparam int DIMM_W     = $clog2(GROUPS * DIMMS_PER_GROUP);
  localparam int QW_W       = $clog2(QW_NUM);
  localparam int NSETS      = 2;

  // ---- front end: decode the request --------------------------------------
  logic [QW_W-1:0] qw;
  logic            in_range, is_multi, pos_ok;
  logic [LP_W-1:0] lp;
  logic [DB_W-1:0] dbi;
  logic [2:0]      shift;
  loc_kind_e       kind_c;
  logic [DIMM_W-1:0] first_c;

  assign qw = QW_W'(int'(req_offset) / QW_BYTES);

  ecc_loc_remap #(
    .SYN_W(SYN_W), .QW_BITS(QW_BITS), .QW_NUM(QW_NUM),
    .QW_W(QW_W), .LP_W(LP_W), .DB_W(DB_W)
  ) u_remap (
    .syn_i(req_syndrome), .qw_i(qw), .in_range_o(in_range), .multi_o(is_multi),
    .pos_ok_o(pos_ok), .lp_o(lp), .dbyte_o(dbi), .shift_o(shift)
  );

  always_comb begin
    if (!req_bank_hit || !in_range) kind_c = LOC_UNKNOWN;
    else if (is_multi)              kind_c = LOC_MULTI;
    else if (!pos_ok)               kind_c = LOC_UNKNOWN;
    else                            kind_c = LOC_SINGLE;
    first_c = (kind_c == LOC_UNKNOWN) ? '0 :
              DIMM_W'((int'(req_bank) % GROUPS) * DIMMS_PER_GROUP);
  end

  // ---- pipeline control ---------------------------------------------------
  logic              s1_v, s2_v, accept;
  loc_kind_e         s1_kind, s2_kind;
  logic [DIMM_W-1:0] s1_first, s2_first;
  logic              s1_set, s2_set;
  logic [2:0]        s1_shift, s2_shift;
  logic [LP_W-1:0]   s1_lp;
  logic [DB_W-1:0]   s1_db;

  assign req_ready = !s1_v && !s2_v;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0;
      s1_kind <= LOC_UNKNOWN; s2_kind <= LOC_UNKNOWN;
      s1_first <= '0; s2_first <= '0;
      s1_set <= 1'b0; s2_set <= 1'b0;
      s1_shift <= '0; s2_shift <= '0;
      s1_lp <= '0; s1_db <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_kind  <= kind_c;
        s1_first <= first_c;
        s1_set   <= !cfg_symmetric;
        s1_shift <= shift;
        s1_lp    <= lp;
        s1_db    <= dbi;
      end
      if (s1_v) begin
        s2_v     <= 1'b1;
        s2_kind  <= s1_kind;
        s2_first <= s1_first;
        s2_set   <= s1_set;
        s2_shift <= s1_shift;
      end else if (s2_v && res_ready) begin
        s2_v <= 1'b0;
      end
    end
  end

  // ---- table storage: one DIMM map and one pin map per set ----------------
  logic [7:0] dm_rd [NSETS];
  logic [7:0] pm_rd [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    ecc_loc_map_ram #(.DEPTH(DMAP_BYTES), .AW(TA_W), .RW(DB_W)) u_dmap (
      .clk(clk), .we(tbl_we && (tbl_set == 1'(g)) && !tbl_kind),
      .waddr(tbl_addr), .wdata(tbl_data),
      .re(s1_v), .raddr(s1_db), .rdata(dm_rd[g])
    );
    ecc_loc_map_ram #(.DEPTH(LINE_BITS), .AW(TA_W), .RW(LP_W)) u_pmap (
      .clk(clk), .we(tbl_we && (tbl_set == 1'(g)) && tbl_kind),
      .waddr(tbl_addr), .wdata(tbl_data),
      .re(s1_v), .raddr(s1_lp), .rdata(pm_rd[g])
    );
  end

  // ---- result assembly ----------------------------------------------------
  logic [7:0] dsel, psel;
  logic       single;

  assign dsel      = s2_set ? dm_rd[1] : dm_rd[0];
  assign psel      = s2_set ? pm_rd[1] : pm_rd[0];
  assign single    = (s2_kind == LOC_SINGLE);
  assign res_valid = s2_v;
  assign res_kind  = s2_kind;
  assign res_dimm  = s2_first + DIMM_W'(single ? dsel[s2_shift] : 1'b0);
  assign res_pin   = single ? psel : 8'd0;

  // ---- assertions -----------------------------------------------------------
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> res_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_kind)
      && $stable(res_dimm) && $stable(res_pin)));

  assert_unknown_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd0) |-> (res_dimm == '0 && res_pin == 8'd0));

  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_kind != 2'd3));

  assert_multi_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2) |->
      (res_pin == 8'd0 && (int'(res_dimm) % DIMMS_PER_GROUP) == 0));
endmodule

// File: tb/tb_ecc_dimm_locator.sv
`timescale 1ns/1ps
module tb_ecc_dimm_locator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_symmetric = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic signed [9:0] req_syndrome = '0;
  logic [5:0] req_offset = '0;
  logic req_bank_hit = 1'b0;
  logic [1:0] req_bank = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [1:0] res_kind;
  logic [2:0] res_dimm;
  logic [7:0] res_pin;
  logic tbl_we = 1'b0, tbl_set = 1'b0, tbl_kind = 1'b0;
  logic [9:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] sh_dm [2][144];
  logic [7:0] sh_pm [2][576];

  always #2.5 clk = ~clk;

  ecc_dimm_locator dut (
    .clk(clk), .rst_n(rst_n), .cfg_symmetric(cfg_symmetric),
    .req_valid(req_valid), .req_ready(req_ready), .req_syndrome(req_syndrome),
    .req_offset(req_offset), .req_bank_hit(req_bank_hit), .req_bank(req_bank),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
    .res_dimm(res_dimm), .res_pin(res_pin), .tbl_we(tbl_we), .tbl_set(tbl_set),
    .tbl_kind(tbl_kind), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit set, input bit kind, input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_set = set; tbl_kind = kind;
    tbl_addr = 10'(addr); tbl_data = 8'(data);
    if (!kind && addr < 144) sh_dm[set][addr] = 8'(data);
    if (kind && addr < 576)  sh_pm[set][addr] = 8'(data);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Reference computation from the requirements (R4..R9)
  task automatic model(input int syn, input int off, input bit hit, input int bank,
                       input bit sym, output int k, output int d, output int p);
    int r, q, lp, rv, st, byt, sel;
    k = 0; d = 0; p = 0;
    if (!hit || syn < -1 || syn > 144) return;
    if (syn == -1) begin k = 2; d = (bank % 2) * 4; return; end
    if (syn < 128) r = syn + 16;
    else if (syn < 144) r = syn - 137;
    else r = 1;
    q  = (off >> 4) & 3;
    lp = (3 - q) * 144 + r;
    if (lp < 0 || lp > 575) return;
    rv  = 575 - lp;
    st  = sym ? 0 : 1;
    byt = int'(sh_dm[st][rv / 4]);
    sel = (byt >> ((3 - rv % 4) * 2)) & 1;
    k = 1; d = (bank % 2) * 4 + sel; p = int'(sh_pm[st][lp]);
  endtask

  task automatic lookup(input int syn, input int off, input bit hit, input int bank,
                        input bit sym, input int stall, input string tag);
    int ek, ed, ep, k0, d0, p0;
    model(syn, off, hit, bank, sym, ek, ed, ep);
    @(negedge clk);
    chk("R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_syndrome = 10'(syn); req_offset = 6'(off);
    req_bank_hit = hit; req_bank = 2'(bank); cfg_symmetric = sym;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_symmetric = ~sym;  // R10: change after acceptance must not matter
    chk("R2 busy after accept", int'(req_ready), 0);
    chk("R2 no early result", int'(res_valid), 0);
    @(negedge clk);
    chk("R2 result after two edges", int'(res_valid), 1);
    chk({tag, " kind"}, int'(res_kind), ek);
    chk({tag, " dimm"}, int'(res_dimm), ed);
    chk({tag, " pin"}, int'(res_pin), ep);
    k0 = int'(res_kind); d0 = int'(res_dimm); p0 = int'(res_pin);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R3 held valid", int'(res_valid), 1);
      chk("R3 held dimm/kind/pin", (int'(res_kind) << 16) | (d0 == int'(res_dimm) ? 0 : 256)
          | int'(res_pin), (k0 << 16) | p0);
      chk("R2 busy while held", int'(req_ready), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R2 result taken", int'(res_valid), 0);
    chk("R2 ready again", int'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset valid", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 valid after reset", int'(res_valid), 0);

    // R11: fill both table sets
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 144; i++) wr(s[0], 1'b0, i, int'($urandom_range(0, 255)));
      for (int i = 0; i < 576; i++) wr(s[0], 1'b1, i, int'($urandom_range(0, 255)));
    end

    // Directed corners
    lookup(-1, 0, 1, 1, 1, 0, "R5 multi bank1");
    lookup(-1, 16, 1, 2, 0, 1, "R5 multi bank2");
    lookup(145, 0, 1, 0, 1, 0, "R4 above range");
    lookup(-2, 0, 1, 0, 1, 0, "R4 below range");
    lookup(10, 0, 0, 1, 1, 0, "R4 no bank hit");
    lookup(130, 48, 1, 0, 1, 0, "R7 negative position");
    lookup(140, 48, 1, 1, 1, 0, "R6 remap 128-143");
    lookup(144, 32, 1, 0, 0, 0, "R6 remap 144");
    lookup(0, 0, 1, 0, 1, 0, "R6 remap low");
    lookup(127, 0, 1, 3, 0, 2, "R8 last line bit");
    lookup(50, 48, 1, 1, 1, 0, "R9 pin q3");
    lookup(50, 48, 1, 1, 0, 0, "R10 set1 same request");

    // R11: out-of-range DIMM-map address must not alias onto byte 5
    wr(1'b0, 1'b0, 5, 0);
    wr(1'b0, 1'b0, 261, 255);
    wr(1'b0, 1'b1, 600, 77);
    lookup(107, 0, 1, 0, 1, 0, "R11 ignored high write");
    chk("R11 alias dimm", int'(res_dimm), 0);

    // Constrained random
    for (int n = 0; n < 300; n++) begin
      int pick, syn;
      pick = int'($urandom_range(0, 9));
      if (pick == 0)      syn = -1 - int'($urandom_range(1, 200));
      else if (pick == 1) syn = int'($urandom_range(145, 400));
      else                syn = int'($urandom_range(0, 146)) - 1;
      lookup(syn, int'($urandom_range(0, 63)), $urandom_range(0, 9) != 0,
             int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             int'($urandom_range(0, 2)), "R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule